// File: doc/BRIEF.md
# Washer Motor Cycle Sequencer

This block sequences a washing-machine drum through a fixed, timed program. A start key launches the program. Each wash cycle runs a rest of 2 s, forward rotation for 8 s, a rest of 2 s, reverse rotation for 8 s and a final rest of 2 s. The cycle runs three times. A buzzer then sounds for 3 s, and the block settles in a finished state until start is pressed again.

All timing advances on an internal one-second tick. The tick is derived from the system clock by a counter whose length is a parameter. The counter runs only while the program is active and not paused, so a pause freezes the sub-second fraction as well. Both keys pass through a two-flop synchronizer before use. Start acts on its rising edge. Pause is a level: holding it freezes everything, and releasing it resumes from the same point.

The outputs drive three motor indicators and a buzzer line. They also give a 4-bit countdown of the seconds left in the current phase, suitable for one seven-segment digit, and a 4-bit count of completed wash cycles.

Top module: `washer_seq`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a clock edge) puts the block in the ready state. In that state `phase_left` = 0, `cycles_done` = 0, `buzzer` = 0, `stop_on` = 1, `fwd_on` = 0 and `rev_on` = 0.
- R2: A rising edge of the synchronized start key, seen in the ready or finished state, starts the program. It clears `cycles_done` to 0 and enters the first rest with `phase_left` = 2.
- R3: Phases follow a fixed order with fixed lengths: rest 2, forward 8, rest 2, reverse 8, rest 2. `phase_left` shows the seconds left as plain binary. It loads the phase length on entry and decreases by exactly 1 per tick, down to 1.
- R4: `fwd_on` is 1 only in the forward phase while not paused. `rev_on` is 1 only in the reverse phase while not paused. `stop_on` is 1 at all other times. Exactly one of the three is 1 at every moment.
- R5: `cycles_done` increases by 1 as each wash cycle's final rest ends. After the third increment the block enters the buzzer phase instead of a new cycle.
- R6: `buzzer` is 1 for 3 ticks of the buzzer phase, during which `phase_left` counts 3, 2, 1. The block then enters the finished state with `phase_left` = 0, `buzzer` = 0 and `cycles_done` = 3.
- R7: While the synchronized pause key is high during an active program, the phase, `phase_left`, `cycles_done` and the sub-second tick count all hold. `buzzer`, `fwd_on` and `rev_on` are 0 and `stop_on` is 1. On release, timing resumes from exactly the same point.
- R8: A start edge during an active program, including the buzzer phase, has no effect. Holding start across completion does not restart the program.
- R9: Each key reaches the sequencer through a two-flop synchronizer. A start press presented before clock edge e first changes the outputs after edge e+2.
- R10: One tick equals TICK_DIV clock cycles of unpaused activity. The first decrement of `phase_left` happens TICK_DIV clock edges after the edge that starts the program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_key | input | 1 | Start key, asynchronous level |
| pause_key | input | 1 | Pause key, asynchronous level, held to pause |
| fwd_on | output | 1 | Forward rotation indicator |
| rev_on | output | 1 | Reverse rotation indicator |
| stop_on | output | 1 | Motor stopped indicator |
| buzzer | output | 1 | Buzzer drive, high during the end-of-program alert |
| phase_left | output | 4 | Seconds left in the current phase, binary |
| cycles_done | output | 4 | Completed wash cycles, binary |

## Verification
The bench goes after the boundaries of the program.

- **Last cycle.** The third cycle's final rest must lead to the buzzer and not to a fourth cycle. A design that compared the count off by one would run two or four cycles.
- **Held start.** Start held across completion must not relaunch the program. A level-sensitive start would loop forever.
- **Pause and the tick.** A pause must also freeze the sub-second tick count. A free-running tick would make the first second after resume short.
- **Start during a run or pause.** A start press during a run or a pause must change nothing. A design that reloaded on any start edge would restart from cycle 0.

Exact key-to-output latency and first-tick timing are checked directly, to catch a missing or extra synchronizer stage.

// File: rtl/washer_pkg.sv
// Shared types for the washer sequencer: the program phase encoding.
package washer_pkg;
    typedef enum logic [2:0] {
        PH_READY  = 3'd0,
        PH_REST_A = 3'd1,
        PH_FWD    = 3'd2,
        PH_REST_B = 3'd3,
        PH_REV    = 3'd4,
        PH_REST_C = 3'd5,
        PH_BUZZ   = 3'd6,
        PH_DONE   = 3'd7
    } phase_t;
endpackage

// File: rtl/washer_key_sync.sv
// Two-flop synchronizer for a bank of asynchronous key levels.
// Assumes the keys are already debounced; adds two cycles of latency.
module washer_key_sync #(
    parameter int N_KEYS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_KEYS-1:0] key_raw,
    output logic [N_KEYS-1:0] key_sync
);
    logic [N_KEYS-1:0] meta_q;

    for (genvar k = 0; k < N_KEYS; k++) begin : g_key
        // Two flops per key line, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q[k]   <= 1'b0;
                key_sync[k] <= 1'b0;
            end else begin
                meta_q[k]   <= key_raw[k];
                key_sync[k] <= meta_q[k];
            end
        end
    end
endmodule

// File: rtl/washer_tick_gen.sv
// One-second tick generator. It counts only while the program is active and
// not held, so a pause keeps the sub-second fraction. It clears when inactive.
module washer_tick_gen #(
    parameter int TICK_DIV = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic hold,
    output logic tick
);
    localparam int CW = $clog2(TICK_DIV + 1);
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = active && !hold && (cnt_q == LAST);

    // Advance the sub-second counter while running, wrap on the tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt_q <= '0;
        end else if (!hold) begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/washer_seq_core.sv
// Program state machine: phase order, per-phase countdown and cycle count.
// Assumes synchronized key levels and a single-cycle tick enable.
module washer_seq_core
    import washer_pkg::*;
#(
    parameter int REST_S   = 2,
    parameter int TURN_S   = 8,
    parameter int BUZZ_S   = 3,
    parameter int N_CYCLES = 3,
    parameter int REM_W    = 4,
    parameter int CYC_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_lvl,
    input  logic             tick,
    output phase_t           phase,
    output logic [REM_W-1:0] remain,
    output logic [CYC_W-1:0] cycles,
    output logic             active
);
    localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(N_CYCLES - 1);

    logic   start_d;
    logic   start_edge;
    logic   idle_like;
    phase_t nxt;

    // Length in seconds of each phase.
    function automatic logic [REM_W-1:0] dur(input phase_t p);
        case (p)
            PH_REST_A, PH_REST_B, PH_REST_C: dur = REM_W'(REST_S);
            PH_FWD, PH_REV:                  dur = REM_W'(TURN_S);
            PH_BUZZ:                         dur = REM_W'(BUZZ_S);
            default:                         dur = '0;
        endcase
    endfunction

    assign start_edge = start_lvl && !start_d;
    assign idle_like  = (phase == PH_READY) || (phase == PH_DONE);
    assign active     = !idle_like;

    // Successor phase when the current one expires.
    always_comb begin
        case (phase)
            PH_REST_A: nxt = PH_FWD;
            PH_FWD:    nxt = PH_REST_B;
            PH_REST_B: nxt = PH_REV;
            PH_REV:    nxt = PH_REST_C;
            PH_REST_C: nxt = (cycles == LAST_CYC) ? PH_BUZZ : PH_REST_A;
            PH_BUZZ:   nxt = PH_DONE;
            default:   nxt = phase;
        endcase
    end

    // Launch on a start edge when idle, otherwise step on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_READY;
            remain  <= '0;
            cycles  <= '0;
            start_d <= 1'b0;
        end else begin
            start_d <= start_lvl;
            if (start_edge && idle_like) begin
                phase  <= PH_REST_A;
                remain <= dur(PH_REST_A);
                cycles <= '0;
            end else if (tick) begin
                if (remain > REM_W'(1)) begin
                    remain <= remain - 1'b1;
                end else begin
                    phase  <= nxt;
                    remain <= dur(nxt);
                    if (phase == PH_REST_C) cycles <= cycles + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/washer_seq.sv
// Top of the washer motor sequencer: key synchronizer, tick generator and
// program state machine, plus the indicator and buzzer output decode.
// Assumes one clock domain; start acts on its edge, pause is a held level.
module washer_seq
    import washer_pkg::*;
#(
    parameter int TICK_DIV = 50_000_000,
    parameter int REST_S   = 2,
    parameter int TURN_S   = 8,
    parameter int BUZZ_S   = 3,
    parameter int N_CYCLES = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_key,
    input  logic       pause_key,
    output logic       fwd_on,
    output logic       rev_on,
    output logic       stop_on,
    output logic       buzzer,
    output logic [3:0] phase_left,
    output logic [3:0] cycles_done
);
    logic [1:0] keys_s;
    logic       pause_s;
    logic       tick;
    logic       active;
    phase_t     phase;

    washer_key_sync #(.N_KEYS(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_raw  ({pause_key, start_key}),
        .key_sync (keys_s)
    );

    assign pause_s = keys_s[1];

    washer_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .hold   (pause_s),
        .tick   (tick)
    );

    washer_seq_core #(
        .REST_S   (REST_S),
        .TURN_S   (TURN_S),
        .BUZZ_S   (BUZZ_S),
        .N_CYCLES (N_CYCLES),
        .REM_W    (4),
        .CYC_W    (4)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_lvl (keys_s[0]),
        .tick      (tick),
        .phase     (phase),
        .remain    (phase_left),
        .cycles    (cycles_done),
        .active    (active)
    );

    // Output decode: motor runs and buzzer sounds only while not paused.
    always_comb begin
        fwd_on  = (phase == PH_FWD) && !pause_s;
        rev_on  = (phase == PH_REV) && !pause_s;
        stop_on = !(fwd_on || rev_on);
        buzzer  = (phase == PH_BUZZ) && !pause_s;
    end
endmodule

// File: rtl/washer_seq_chk.sv
// Property checker for washer_seq, bound to every instance of the top.
module washer_seq_chk
    import washer_pkg::*;
#(
    parameter int N_CYCLES = 3,
    parameter int TURN_S   = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       fwd_on,
    input logic       rev_on,
    input logic       stop_on,
    input logic       buzzer,
    input logic [3:0] phase_left,
    input logic [3:0] cycles_done,
    input phase_t     phase,
    input logic       pause_s
);
    logic running;
    assign running = (phase != PH_READY) && (phase != PH_DONE);

    assert_one_indicator_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({fwd_on, rev_on, stop_on}) == 1);

    assert_countdown_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        phase_left <= 4'(TURN_S));

    assert_countdown_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == $past(phase) && phase_left != $past(phase_left))
        |-> phase_left == 4'($past(phase_left) - 4'd1));

    assert_cycle_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cycles_done != $past(cycles_done))
        |-> (cycles_done == 4'($past(cycles_done) + 4'd1) || cycles_done == 4'd0));

    assert_buzz_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        buzzer |-> cycles_done == 4'(N_CYCLES));

    assert_pause_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_s && running)
        |=> ($stable(phase) && $stable(phase_left) && $stable(cycles_done)));

    assert_pause_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pause_s |-> (!buzzer && stop_on));
endmodule

bind washer_seq washer_seq_chk #(.N_CYCLES(N_CYCLES), .TURN_S(TURN_S)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fwd_on      (fwd_on),
    .rev_on      (rev_on),
    .stop_on     (stop_on),
    .buzzer      (buzzer),
    .phase_left  (phase_left),
    .cycles_done (cycles_done),
    .phase       (phase),
    .pause_s     (pause_s)
);

// File: tb/washer_seq_bench.sv
`timescale 1ns/1ps
// Bench for washer_seq: directed corner cases, then random key activity
// compared each cycle against a requirement-level reference model.
module washer_seq_bench;
    localparam int DIV = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_key = 1'b0;
    logic pause_key = 1'b0;
    logic fwd_on, rev_on, stop_on, buzzer;
    logic [3:0] phase_left, cycles_done;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    washer_seq #(.TICK_DIV(DIV)) u_washer_seq (
        .clk(clk), .rst_n(rst_n), .start_key(start_key), .pause_key(pause_key),
        .fwd_on(fwd_on), .rev_on(rev_on), .stop_on(stop_on), .buzzer(buzzer),
        .phase_left(phase_left), .cycles_done(cycles_done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: got %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    // Reference model; phases 0 ready, 1 rest, 2 fwd, 3 rest, 4 rev, 5 rest, 6 buzz, 7 done.
    function automatic int dur_of(input int p);
        case (p)
            1, 3, 5: return 2;
            2, 4:    return 8;
            6:       return 3;
            default: return 0;
        endcase
    endfunction

    function automatic int next_of(input int p, input int cyc);
        case (p)
            5:       return (cyc == 2) ? 6 : 1;
            6:       return 7;
            default: return p + 1;
        endcase
    endfunction

    int m_ph = 0, m_rem = 0, m_cyc = 0, m_cnt = 0;
    bit s1 = 0, s2 = 0, sd = 0, p1 = 0, p2 = 0;

    always @(posedge clk) begin
        bit edge_s, run, tk;
        if (!rst_n) begin
            m_ph = 0; m_rem = 0; m_cyc = 0; m_cnt = 0;
            s1 = 0; s2 = 0; sd = 0; p1 = 0; p2 = 0;
        end else begin
            edge_s = s2 && !sd;
            run    = (m_ph != 0) && (m_ph != 7);
            tk     = run && !p2 && (m_cnt == DIV - 1);
            if (!run) m_cnt = 0;
            else if (!p2) m_cnt = tk ? 0 : m_cnt + 1;
            if (edge_s && !run) begin
                m_ph = 1; m_rem = 2; m_cyc = 0;
            end else if (tk) begin
                if (m_rem > 1) m_rem--;
                else begin
                    if (m_ph == 5) m_cyc++;
                    m_ph  = next_of(m_ph, m_cyc - ((m_ph == 5) ? 1 : 0));
                    m_rem = dur_of(m_ph);
                end
            end
            sd = s2; s2 = s1; s1 = start_key;
            p2 = p1; p1 = pause_key;
        end
    end

    // Per-cycle comparison against the model, away from the clock edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 fwd_on",  fwd_on,  (m_ph == 2) && !p2);
            chk("R4 rev_on",  rev_on,  (m_ph == 4) && !p2);
            chk("R4 stop_on", stop_on, !(((m_ph == 2) || (m_ph == 4)) && !p2));
            chk("R6 buzzer",  buzzer,  (m_ph == 6) && !p2);
            chk("R3 phase_left", phase_left, m_rem);
            chk("R5 cycles_done", cycles_done, m_cyc);
        end
    end

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: run did not complete, got 0 expected 1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int hold_rem, hold_cyc;
        void'($urandom(32'h5EED_0C1E));
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 phase_left", phase_left, 0);
        chk("R1 cycles_done", cycles_done, 0);
        chk("R1 stop_on", stop_on, 1);
        chk("R1 buzzer", buzzer, 0);
        chk("R1 fwd_on", fwd_on, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R9: start latency through the synchronizer
        start_key = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R9 no change after two edges", phase_left, 0);
        @(posedge clk); @(negedge clk);
        chk("R2 first rest length", phase_left, 2);
        chk("R2 cycles cleared", cycles_done, 0);
        // R10: first tick timing
        repeat (DIV - 1) @(posedge clk);
        @(negedge clk);
        chk("R10 before first tick", phase_left, 2);
        @(posedge clk); @(negedge clk);
        chk("R10 first tick", phase_left, 1);

        // R8: start held through the whole program must not relaunch
        repeat (75 * DIV) @(negedge clk);
        chk("R6 final cycles", cycles_done, 3);
        chk("R6 final countdown", phase_left, 0);
        chk("R8 held start no relaunch", buzzer, 0);
        repeat (10 * DIV) @(negedge clk);
        chk("R8 still finished", cycles_done, 3);

        // R2: restart after completion
        start_key = 1'b0;
        repeat (4) @(negedge clk);
        start_key = 1'b1;
        repeat (3) @(negedge clk);
        start_key = 1'b0;
        repeat (12 * DIV) @(negedge clk);
        chk("R2 restart clears count", cycles_done, 0);

        // R7: pause freezes state; R8: start during pause ignored
        pause_key = 1'b1;
        repeat (4) @(negedge clk);
        hold_rem = phase_left;
        hold_cyc = cycles_done;
        repeat (40) @(negedge clk);
        chk("R7 countdown frozen", phase_left, hold_rem);
        chk("R7 motor stopped", stop_on, 1);
        start_key = 1'b1;
        repeat (3) @(negedge clk);
        start_key = 1'b0;
        repeat (6) @(negedge clk);
        chk("R8 start ignored remain", phase_left, hold_rem);
        chk("R8 start ignored cycles", cycles_done, hold_cyc);
        pause_key = 1'b0;

        // Random key activity against the model
        for (int i = 0; i < 30000; i++) begin
            @(negedge clk);
            if ($urandom % 150 == 0) pause_key = ~pause_key;
            if (!start_key && ($urandom % 300 == 0)) start_key = 1'b1;
            else if (start_key && ($urandom % 4 == 0)) start_key = 1'b0;
        end
        pause_key = 1'b0;
        start_key = 1'b0;
        repeat (100 * DIV) @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule